// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer that sits between two unrelated clock domains. Words enter on the write clock and leave on the read clock. It is 36 bits wide and its depth is a power-of-two parameter. A mode input is sampled while reset is high and selects one of two read behaviours. In standard mode a word reaches the output register only when a read is requested. In fall-through mode the oldest word is presented on its own, and a read request advances to the next word.

The write side reports a ready flag and an active-low almost-full flag. Both are computed in the write clock domain. The read side reports a ready flag and an active-low almost-empty flag. Both are computed in the read clock domain. The two offsets that set the almost thresholds are taken from configuration inputs while reset is high. They can be loaded again later with a strobe in the matching clock domain. The occupancy that drives every flag counts only the words in memory. A word already moved into the output register is not counted.

Top module: `dmfifo`

## Requirements
- R1: Every word accepted on the write port (wr_en high while wr_rdy is high at a rising wclk edge) is delivered on rd_data exactly once, with the same value and in the same order.
- R2: wr_rdy is low exactly when the memory holds DEPTH words. A write attempted while wr_rdy is low stores nothing, and later reads never return that word.
- R3: In standard mode rd_rdy is low exactly when the memory holds no word. A read attempted while rd_rdy is low leaves rd_data unchanged. Right after reset, wr_rdy is 1, rd_rdy is 0 and rd_data is 0.
- R4: In standard mode rd_data changes only on a rising rclk edge where rd_en and rd_rdy are both high. The next word is visible after that edge, and a word is never loaded without a read.
- R5: In fall-through mode the first word written into an empty FIFO moves into the output register without a read. rd_rdy rises on the same rclk edge.
- R6: In fall-through mode, while rd_rdy is high and rd_en is low, rd_data and rd_rdy hold. A read with rd_rdy high replaces rd_data with the next word, or drops rd_rdy if the memory is empty.
- R7: The word held in the output register is not counted as occupancy. In fall-through mode the FIFO accepts DEPTH+1 words before wr_rdy stays low. A single word held in the output register leaves the almost-empty count at zero.
- R8: almost_empty_n is low while the memory holds at most AE words and high while it holds more, where AE is the current almost-empty offset. The flag is evaluated in the read clock domain.
- R9: almost_full_n is low while the memory holds DEPTH-AF words or more and high below that, where AF is the current almost-full offset. The flag is evaluated in the write clock domain.
- R10: Both offsets are taken from cfg_ae_off and cfg_af_off while rst is high. Changing those inputs later has no effect unless ae_load (on rclk) or af_load (on wclk) is high, which loads the new value.
- R11: The mode is taken from mode_fwft while rst is high. Changing mode_fwft afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| mode_fwft | input | 1 | Mode select sampled in reset: 1 fall-through, 0 standard |
| cfg_ae_off | input | AW+1 | Almost-empty offset value |
| cfg_af_off | input | AW+1 | Almost-full offset value |
| af_load | input | 1 | Load cfg_af_off on wclk |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| wr_rdy | output | 1 | Room for a write (full flag, active low) |
| almost_full_n | output | 1 | Almost-full flag, active low |
| ae_load | input | 1 | Load cfg_ae_off on rclk |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Output register |
| rd_rdy | output | 1 | Standard: memory not empty. Fall-through: output word valid |
| almost_empty_n | output | 1 | Almost-empty flag, active low |

## Verification
The assertions check several properties on every cycle:
- Neither domain's occupancy ever passes DEPTH, so there is no overflow and no pointer underflow.
- The output register holds when no read is accepted in standard mode.
- The output word and its ready flag hold under a stalled read in fall-through mode.
- An empty memory always implies almost-empty, and a full memory always implies almost-full.

Only the bench scenarios show the rest:
- Data order across unrelated clocks.
- Each exact threshold for both offsets, and a reload through the strobes.
- The automatic first-word load and the DEPTH+1 capacity in fall-through mode.
- That a late change on the mode or offset inputs is ignored.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dmf_ptr_sync.sv
// Two-stage synchroniser for a Gray-coded pointer, with binary conversion
// of the synchronised value in the destination domain.
module dmf_ptr_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  // Bit i of the binary value is the XOR of Gray bits i and above.
  always_comb begin
    for (int i = 0; i < W; i++) begin
      bin_out[i] = ^(stage2 >> i);
    end
  end
endmodule

// File: rtl/dmf_ram.sv
// Simple dual-port memory with a registered, enabled read port, shaped for
// block RAM inference. The read register is the FIFO output register.
module dmf_ram #(
  parameter int DW = 36,
  parameter int AW = 11
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dmfifo.sv
module dmfifo
  import dmf_pkg::*;
#(
  parameter int DW    = 36,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          mode_fwft,
  input  logic [PW-1:0] cfg_ae_off,
  input  logic [PW-1:0] cfg_af_off,
  input  logic          af_load,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_rdy,
  output logic          almost_full_n,
  input  logic          ae_load,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_rdy,
  output logic          almost_empty_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] ONE_P   = PW'(1);

  // ---------------- write clock domain ----------------
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_wsync, wcnt, af_off, wptr_nxt;
  logic          wr_go;

  assign wcnt          = wptr_bin - rptr_wsync;
  assign wr_rdy        = (wcnt != DEPTH_P);
  assign almost_full_n = (wcnt < (DEPTH_P - af_off));
  assign wr_go         = wr_en && wr_rdy;
  assign wptr_nxt      = wptr_bin + ONE_P;

  always_ff @(posedge wclk) begin
    if (rst) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
      af_off    <= cfg_af_off;
    end else begin
      if (wr_go) begin
        wptr_bin  <= wptr_nxt;
        wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      end
      if (af_load) af_off <= cfg_af_off;
    end
  end

  // ---------------- read clock domain ----------------
  logic [PW-1:0] rptr_bin, rptr_gray, wptr_rsync, rcnt, ae_off, rptr_nxt;
  logic          mem_empty, out_valid, load, rd_go;
  rd_mode_e      mode_q;

  assign rcnt           = wptr_rsync - rptr_bin;
  assign mem_empty      = (rcnt == '0);
  assign almost_empty_n = (rcnt > ae_off);
  assign rd_rdy         = (mode_q == RD_FWFT) ? out_valid : !mem_empty;
  assign rd_go          = rd_en && rd_rdy;
  // A load moves the oldest memory word into the output register and frees
  // its location, so the occupancy no longer counts it.
  assign load           = (mode_q == RD_FWFT) ? (!mem_empty && (!out_valid || rd_en))
                                              : rd_go;
  assign rptr_nxt       = rptr_bin + ONE_P;

  always_ff @(posedge rclk) begin
    if (rst) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      out_valid <= 1'b0;
      mode_q    <= mode_fwft ? RD_FWFT : RD_STD;
      ae_off    <= cfg_ae_off;
    end else begin
      if (load) begin
        rptr_bin  <= rptr_nxt;
        rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
      end
      if (mode_q == RD_FWFT) begin
        if (load)       out_valid <= 1'b1;
        else if (rd_en) out_valid <= 1'b0;
      end
      if (ae_load) ae_off <= cfg_ae_off;
    end
  end

  // ---------------- crossings and storage ----------------
  dmf_ptr_sync #(.W(PW)) u_wptr_to_rd (
    .clk     (rclk),
    .rst     (rst),
    .gray_in (wptr_gray),
    .bin_out (wptr_rsync)
  );

  dmf_ptr_sync #(.W(PW)) u_rptr_to_wr (
    .clk     (wclk),
    .rst     (rst),
    .gray_in (rptr_gray),
    .bin_out (rptr_wsync)
  );

  dmf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wclk),
    .we    (wr_go),
    .waddr (wptr_bin[AW-1:0]),
    .wdata (wr_data),
    .rclk  (rclk),
    .rst   (rst),
    .re    (load),
    .raddr (rptr_bin[AW-1:0]),
    .q     (rd_data)
  );

  // ---------------- assertions ----------------
  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (rst)
    wcnt <= DEPTH_P)
    else $error("write-side occupancy above depth");

  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (rst)
    rcnt <= DEPTH_P)
    else $error("read-side occupancy wrapped");

  p_std_hold_r4: assert property (@(posedge rclk) disable iff (rst)
    (mode_q == RD_STD && !(rd_en && rd_rdy)) |=> $stable(rd_data))
    else $error("standard-mode output changed without a read");

  p_fwft_hold_r6: assert property (@(posedge rclk) disable iff (rst)
    (mode_q == RD_FWFT && rd_rdy && !rd_en) |=> (rd_rdy && $stable(rd_data)))
    else $error("fall-through output not held while stalled");

  p_empty_ae_r8: assert property (@(posedge rclk) disable iff (rst)
    mem_empty |-> !almost_empty_n)
    else $error("empty memory without almost-empty");

  p_full_af_r9: assert property (@(posedge wclk) disable iff (rst)
    !wr_rdy |-> !almost_full_n)
    else $error("full memory without almost-full");
endmodule

// File: tb/test_dmfifo.sv
module test_dmfifo;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW    = 36;
  localparam int DEPTH = 16;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic          wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
  logic          mode_fwft = 1'b0;
  logic [PW-1:0] cfg_ae_off = '0, cfg_af_off = '0;
  logic          af_load = 1'b0, ae_load = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_rdy, almost_full_n, rd_rdy, almost_empty_n;
  logic [DW-1:0] rd_data;

  always #2.5 wclk = ~wclk;  // 200 MHz
  always #3.7 rclk = ~rclk;  // unrelated read clock

  dmfifo #(.DW(DW), .DEPTH(DEPTH)) i_dmfifo (
    .wclk, .rclk, .rst, .mode_fwft, .cfg_ae_off, .cfg_af_off, .af_load,
    .wr_en, .wr_data, .wr_rdy, .almost_full_n, .ae_load, .rd_en,
    .rd_data, .rd_rdy, .almost_empty_n
  );

  int            n_chk = 0, n_err = 0;
  logic [DW-1:0] model_q[$];
  bit            fwft_b = 0;
  int            xb = 0, yb = 0;
  int            serial = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] next_word();
    serial++;
    return DW'(64'h9_C0DE_0000 + serial * 17);
  endfunction

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
  endtask

  task automatic do_reset(input bit fw, input int x, input int y);
    rst = 1'b1; mode_fwft = fw;
    cfg_ae_off = PW'(x); cfg_af_off = PW'(y);
    repeat (4) @(posedge rclk);
    repeat (2) @(posedge wclk);
    @(negedge wclk) rst = 1'b0;
    model_q.delete();
    fwft_b = fw; xb = x; yb = y;
    settle();
  endtask

  task automatic push(input logic [DW-1:0] d, output bit acc);
    @(negedge wclk);
    acc = wr_rdy; wr_en = 1'b1; wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
    if (acc) model_q.push_back(d);
  endtask

  task automatic pop(output bit ok);
    logic [DW-1:0] prev, exp;
    @(negedge rclk);
    ok = rd_rdy; prev = rd_data;
    if (fwft_b && ok) chk(rd_data == model_q[0], "R6", rd_data, model_q[0]);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    if (ok) begin
      exp = model_q.pop_front();
      if (!fwft_b) chk(rd_data == exp, "R1", rd_data, exp);
    end else if (!fwft_b) begin
      chk(rd_data == prev, "R3", rd_data, prev);
    end
  endtask

  task automatic flags_check();
    int n = model_q.size();
    int m = fwft_b ? ((n > 0) ? n - 1 : 0) : n;
    @(negedge wclk);
    chk(wr_rdy == (m != DEPTH), "R2", wr_rdy, (m != DEPTH));
    chk(almost_full_n == (m < DEPTH - yb), "R9", almost_full_n, (m < DEPTH - yb));
    @(negedge rclk);
    chk(rd_rdy == (n > 0), fwft_b ? "R5" : "R3", rd_rdy, (n > 0));
    chk(almost_empty_n == (m > xb), "R8", almost_empty_n, (m > xb));
  endtask

  task automatic pulse_ae(input int v);
    @(negedge rclk); cfg_ae_off = PW'(v); ae_load = 1'b1;
    @(negedge rclk); ae_load = 1'b0;
    xb = v;
  endtask

  task automatic pulse_af(input int v);
    @(negedge wclk); cfg_af_off = PW'(v); af_load = 1'b1;
    @(negedge wclk); af_load = 1'b0;
    yb = v;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #400us;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit acc, ok;
    logic [DW-1:0] held, w;

    // ---------- standard mode, AE=2, AF=3 ----------
    do_reset(1'b0, 2, 3);
    chk(rd_data == '0, "R3", rd_data, 0);
    flags_check();
    cfg_ae_off = PW'(7); cfg_af_off = PW'(9);  // no load strobe: ignored (R10)
    repeat (3) begin push(next_word(), acc); end
    settle();
    flags_check();
    @(negedge rclk);
    chk(almost_empty_n == 1'b1, "R10", almost_empty_n, 1);
    @(negedge wclk);
    chk(almost_full_n == 1'b1, "R10", almost_full_n, 1);
    pulse_ae(5); pulse_af(13);
    settle();
    @(negedge rclk);
    chk(almost_empty_n == 1'b0, "R10", almost_empty_n, 0);
    @(negedge wclk);
    chk(almost_full_n == 1'b0, "R10", almost_full_n, 0);
    pulse_ae(2); pulse_af(3);
    // no automatic load in standard mode, output held while idle (R4)
    @(negedge rclk); held = rd_data;
    repeat (6) @(negedge rclk);
    chk(rd_data == held, "R4", rd_data, held);
    for (int k = 4; k <= DEPTH; k++) begin
      push(next_word(), acc);
      settle();
      flags_check();
    end
    push(next_word(), acc);  // write while full
    chk(acc == 1'b0, "R2", acc, 0);
    settle();
    flags_check();
    while (model_q.size() > 0) begin
      pop(ok);
      if (model_q.size() == DEPTH / 2) begin settle(); flags_check(); end
    end
    settle();
    flags_check();
    pop(ok);  // read while empty
    chk(ok == 1'b0, "R3", ok, 0);
    // late change of the mode input is ignored (R11)
    @(negedge rclk); held = rd_data;
    mode_fwft = 1'b1;
    w = next_word();
    push(w, acc);
    settle();
    @(negedge rclk);
    chk(rd_data == held, "R11", rd_data, held);
    chk(rd_rdy == 1'b1, "R11", rd_rdy, 1);
    pop(ok);
    chk(rd_data == w, "R4", rd_data, w);

    // ---------- fall-through mode, AE=0, AF=0 ----------
    do_reset(1'b1, 0, 0);
    flags_check();
    w = next_word();
    push(w, acc);
    settle();
    @(negedge rclk);
    chk(rd_rdy == 1'b1, "R5", rd_rdy, 1);
    chk(rd_data == w, "R5", rd_data, w);
    chk(almost_empty_n == 1'b0, "R7", almost_empty_n, 0);
    push(next_word(), acc);
    settle();
    @(negedge rclk);
    chk(almost_empty_n == 1'b1, "R7", almost_empty_n, 1);
    held = rd_data;
    repeat (5) @(negedge rclk);
    chk(rd_data == held && rd_rdy, "R6", rd_data, held);
    // fill until the write side refuses even after settling
    forever begin
      push(next_word(), acc);
      if (!acc) begin
        settle();
        push(next_word(), acc);
        if (!acc) break;
      end
    end
    chk(model_q.size() == DEPTH + 1, "R7", model_q.size(), DEPTH + 1);
    settle();
    flags_check();
    while (model_q.size() > 0) pop(ok);
    settle();
    flags_check();
    pop(ok);  // read while output not ready
    chk(ok == 1'b0, "R6", ok, 0);
    // concurrent traffic across the two clocks
    fork
      begin
        for (int k = 0; k < 40; k++) begin
          w = next_word();
          do push(w, acc); while (!acc);
        end
      end
      begin
        int got = 0;
        while (got < 40) begin
          bit okc;
          pop(okc);
          if (okc) got++;
        end
      end
    join
    settle();
    chk(model_q.size() == 0, "R1", model_q.size(), 0);
    flags_check();
    finish_run();
  end
endmodule